// File: doc/BRIEF.md
# Multiprocessor Interrupt Source and Delivery Controller

This block collects a small set of external interrupt lines and delivers them to a few processors. Every source has its own sensing mode, priority, vector, mask and routing set. Each processor has a task priority threshold, an acknowledge port that hands back a vector, and an end-of-interrupt port. For each processor the controller keeps the best eligible pending source, and it raises that processor's interrupt line only when the source's priority beats both the processor's threshold and whatever that processor is already servicing.

Software uses one word-wide register port with separate read and write strobes. Reads return their data one cycle later with a valid pulse. Reading a processor's acknowledge register is the handshake that moves a source from pending to in service. Writing its end-of-interrupt register retires the most urgent source that processor is servicing. When nothing is deliverable, an acknowledge read returns a programmable spurious vector.

Word addresses: global control 0x00, spurious vector 0x01, source s configuration at 0x10+2s and its routing at 0x11+2s. Processor p has its task priority at 0x40+4p, acknowledge at 0x41+4p and end-of-interrupt at 0x42+4p.

Top module: `mpic_core`

## Requirements
- R1: After reset no interrupt line is raised, and every source reads back as 0x8000_0000 (masked, everything else zero). Every routing register reads 0, every task priority reads 15, and the spurious vector reads 0xFF.
- R2: The source configuration word holds the mask at bit 31, a read-only active flag at bit 30 (set while the source is pending or in service), the multicast flag at bit 29, positive polarity at bit 23, level sensing at bit 22, the 4-bit priority at bits 19:16 and the 8-bit vector at bits 7:0. Other bits read 0. Read data appears one cycle after the read strobe, together with a one-cycle valid pulse.
- R3: In edge mode, a transition of the line into its active level (high when bit 23 is 1, low when it is 0) marks the source pending. It stays pending after the line returns to inactive.
- R4: In level mode, the pending state follows the line's active level. Removing the level before acknowledge withdraws the request. A level still present after end-of-interrupt requests again.
- R5: A processor's interrupt line is raised only when the best pending priority is strictly greater than that processor's task priority.
- R6: Among eligible sources, the highest priority wins. Ties go to the lowest source number.
- R7: An acknowledge read that finds a deliverable source returns that source's vector and puts the source in service for that processor. An edge-mode source also loses its pending state.
- R8: An acknowledge read with nothing deliverable returns the programmable spurious vector and changes no state.
- R9: A source is delivered only if its priority is strictly greater than the highest priority the processor currently has in service. A source in service is never delivered again until it is retired.
- R10: An end-of-interrupt write retires the highest-priority source in service for that processor, lowest number on a tie. With nothing in service it does nothing.
- R11: A masked source still records pending edges but is never delivered. Clearing the mask lets the recorded request through.
- R12: Bit p of a routing register enables processor p. Without multicast, only the lowest enabled processor is targeted. With multicast, every enabled processor is targeted, and the first to acknowledge takes the source.
- R13: Writing the global control word with bit 31 set returns the whole block to its reset state. Bit 29 (legacy pass-through) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_SRC | External interrupt lines, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register word address |
| wdata | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en |
| irq_o | output | N_CPU | Interrupt request per processor |

## Verification
Edge sources are driven with one-cycle pulses of both polarities, so a latched request can be told apart from a live level. Level sources are raised, withdrawn and held across end-of-interrupt to separate level following from latching. Simultaneous pulses at equal and unequal priorities, followed by a later higher-priority pulse, distinguish the tie rule, the in-service gate and preemption. The same source is routed to both processors with and without multicast to expose the processor-zero bias.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

    localparam int PRIO_W   = 4;
    localparam int VEC_W    = 8;
    localparam int DATA_W   = 32;

    localparam int B_MASK   = 31;
    localparam int B_ACTIVE = 30;
    localparam int B_MCAST  = 29;
    localparam int B_POL    = 23;
    localparam int B_LEVEL  = 22;
    localparam int B_PRIO   = 16;
    localparam int B_GRST   = 31;

    typedef struct packed {
        logic              mask;
        logic              mcast;
        logic              pol;
        logic              lvl;
        logic [PRIO_W-1:0] prio;
        logic [VEC_W-1:0]  vec;
    } src_cfg_t;

    function automatic logic [DATA_W-1:0] vp_word(src_cfg_t c, logic act);
        logic [DATA_W-1:0] w;
        w                          = '0;
        w[B_MASK]                  = c.mask;
        w[B_ACTIVE]                = act;
        w[B_MCAST]                 = c.mcast;
        w[B_POL]                   = c.pol;
        w[B_LEVEL]                 = c.lvl;
        w[B_PRIO+PRIO_W-1:B_PRIO]  = c.prio;
        w[VEC_W-1:0]               = c.vec;
        return w;
    endfunction

    function automatic src_cfg_t vp_decode(logic [DATA_W-1:0] w);
        src_cfg_t c;
        c.mask  = w[B_MASK];
        c.mcast = w[B_MCAST];
        c.pol   = w[B_POL];
        c.lvl   = w[B_LEVEL];
        c.prio  = w[B_PRIO+PRIO_W-1:B_PRIO];
        c.vec   = w[VEC_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/mpic_src_sense.sv
module mpic_src_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw,
    input  logic pol,
    output logic asserted,
    output logic edge_evt
);

    logic prev_d, prev_q;

    // active level is high when pol is set, low otherwise
    assign asserted = (raw == pol);
    assign edge_evt = asserted & ~prev_q;

    always_comb begin
        prev_d = clr ? 1'b1 : asserted;
    end

    // history starts at "asserted" so no false edge follows reset
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/mpic_arb.sv
module mpic_arb
    import mpic_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]             cand,
    input  logic [N_SRC-1:0]             own,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
    output logic                         best_vld,
    output logic [IDX_W-1:0]             best_idx,
    output logic [PRIO_W-1:0]            best_prio,
    output logic                         isv_vld,
    output logic [IDX_W-1:0]             isv_idx,
    output logic [PRIO_W-1:0]            isv_prio
);

    // scan upward, replace only on strictly higher priority: lowest index wins ties
    always_comb begin
        best_vld  = 1'b0;
        best_idx  = '0;
        best_prio = '0;
        isv_vld   = 1'b0;
        isv_idx   = '0;
        isv_prio  = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (cand[s] && (!best_vld || prio[s] > best_prio)) begin
                best_vld  = 1'b1;
                best_idx  = IDX_W'(s);
                best_prio = prio[s];
            end
            if (own[s] && (!isv_vld || prio[s] > isv_prio)) begin
                isv_vld  = 1'b1;
                isv_idx  = IDX_W'(s);
                isv_prio = prio[s];
            end
        end
    end

endmodule

// File: rtl/mpic_core.sv
module mpic_core
    import mpic_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int N_CPU = 2,
    parameter int AW    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               rvalid_o,
    output logic [N_CPU-1:0]   irq_o
);

    localparam int IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int OWN_W      = (N_CPU > 1) ? $clog2(N_CPU) : 1;
    localparam int A_GCTL     = 0;
    localparam int A_SPUR     = 1;
    localparam int SRC_BASE   = 16;
    localparam int CPU_BASE   = 64;
    localparam int CPU_STRIDE = 4;

    typedef struct packed {
        src_cfg_t [N_SRC-1:0]             cfg;
        logic [N_SRC-1:0][N_CPU-1:0]      dest;
        logic [N_SRC-1:0]                 pend;
        logic [N_SRC-1:0]                 insv;
        logic [N_SRC-1:0][OWN_W-1:0]      owner;
        logic [N_CPU-1:0][PRIO_W-1:0]     tp;
        logic [VEC_W-1:0]                 spur;
        logic [DATA_W-1:0]                rdata;
        logic                             rvalid;
    } state_t;

    function automatic state_t reset_state();
        state_t r;
        r = '0;
        for (int s = 0; s < N_SRC; s++) r.cfg[s].mask = 1'b1;
        for (int p = 0; p < N_CPU; p++) r.tp[p] = '1;
        r.spur = '1;
        return r;
    endfunction

    function automatic logic [AW-1:0] a_src(int s, int off);
        return AW'(SRC_BASE + 2 * s + off);
    endfunction

    function automatic logic [AW-1:0] a_cpu(int p, int off);
        return AW'(CPU_BASE + CPU_STRIDE * p + off);
    endfunction

    state_t st_d, st_q;

    logic [N_SRC-1:0]               asrt, edg;
    logic [N_SRC-1:0][N_CPU-1:0]    route;
    logic [N_CPU-1:0][N_SRC-1:0]    cand, own;
    logic [N_SRC-1:0][PRIO_W-1:0]   prio_all;
    logic [N_CPU-1:0]               best_vld, isv_vld, irq_w;
    logic [N_CPU-1:0][IDX_W-1:0]    best_idx, isv_idx;
    logic [N_CPU-1:0][PRIO_W-1:0]   best_prio, isv_prio;
    logic                           soft_rst;
    logic                           unused_wdata;

    assign unused_wdata = ^wdata;
    assign soft_rst     = wr_en && (addr == AW'(A_GCTL)) && wdata[B_GRST];

    // ---------------- per-source sensing ----------------
    for (genvar s = 0; s < N_SRC; s++) begin : g_sense
        mpic_src_sense u_sense (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (soft_rst),
            .raw      (src_i[s]),
            .pol      (st_q.cfg[s].pol),
            .asserted (asrt[s]),
            .edge_evt (edg[s])
        );
    end

    // ---------------- routing and eligibility ----------------
    always_comb begin
        logic [N_CPU-1:0] d;
        for (int s = 0; s < N_SRC; s++) begin
            d           = st_q.dest[s];
            route[s]    = st_q.cfg[s].mcast ? d : (d & (~d + N_CPU'(1)));
            prio_all[s] = st_q.cfg[s].prio;
        end
        for (int p = 0; p < N_CPU; p++) begin
            for (int s = 0; s < N_SRC; s++) begin
                cand[p][s] = st_q.pend[s] && !st_q.cfg[s].mask &&
                             !st_q.insv[s] && route[s][p];
                own[p][s]  = st_q.insv[s] && (st_q.owner[s] == OWN_W'(p));
            end
        end
    end

    // ---------------- per-processor selection ----------------
    for (genvar p = 0; p < N_CPU; p++) begin : g_cpu
        mpic_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
            .cand      (cand[p]),
            .own       (own[p]),
            .prio      (prio_all),
            .best_vld  (best_vld[p]),
            .best_idx  (best_idx[p]),
            .best_prio (best_prio[p]),
            .isv_vld   (isv_vld[p]),
            .isv_idx   (isv_idx[p]),
            .isv_prio  (isv_prio[p])
        );
        // isv_prio is zero when nothing is in service; tp >= 0 keeps prio 0 out
        assign irq_w[p] = best_vld[p] && (best_prio[p] > st_q.tp[p]) &&
                          (best_prio[p] > isv_prio[p]);
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;

        if (wr_en) begin
            if (addr == AW'(A_SPUR)) st_d.spur = wdata[VEC_W-1:0];
            for (int s = 0; s < N_SRC; s++) begin
                if (addr == a_src(s, 0)) st_d.cfg[s]  = vp_decode(wdata);
                if (addr == a_src(s, 1)) st_d.dest[s] = wdata[N_CPU-1:0];
            end
            for (int p = 0; p < N_CPU; p++) begin
                if (addr == a_cpu(p, 0)) st_d.tp[p] = wdata[PRIO_W-1:0];
                if (addr == a_cpu(p, 2) && isv_vld[p]) st_d.insv[isv_idx[p]] = 1'b0;
            end
        end

        if (rd_en) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = '0;
            if (addr == AW'(A_SPUR)) st_d.rdata = DATA_W'(st_q.spur);
            for (int s = 0; s < N_SRC; s++) begin
                if (addr == a_src(s, 0))
                    st_d.rdata = vp_word(st_q.cfg[s], st_q.pend[s] | st_q.insv[s]);
                if (addr == a_src(s, 1)) st_d.rdata = DATA_W'(st_q.dest[s]);
            end
            for (int p = 0; p < N_CPU; p++) begin
                if (addr == a_cpu(p, 0)) st_d.rdata = DATA_W'(st_q.tp[p]);
                if (addr == a_cpu(p, 1)) begin
                    if (irq_w[p]) begin
                        st_d.rdata                = DATA_W'(st_q.cfg[best_idx[p]].vec);
                        st_d.insv[best_idx[p]]    = 1'b1;
                        st_d.owner[best_idx[p]]   = OWN_W'(p);
                        if (!st_q.cfg[best_idx[p]].lvl) st_d.pend[best_idx[p]] = 1'b0;
                    end else begin
                        st_d.rdata = DATA_W'(st_q.spur);
                    end
                end
            end
        end

        // line sensing after the acknowledge clear: a fresh edge wins
        for (int s = 0; s < N_SRC; s++) begin
            if (st_q.cfg[s].lvl) st_d.pend[s] = asrt[s];
            else if (edg[s])     st_d.pend[s] = 1'b1;
        end

        if (soft_rst) st_d = reset_state();
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign rdata_o  = st_q.rdata;
    assign rvalid_o = st_q.rvalid;
    assign irq_o    = irq_w;

    // ---------------- assertions ----------------
    assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid_o);

    for (genvar p = 0; p < N_CPU; p++) begin : g_chk_cpu
        assert_best_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
            best_vld[p] |-> cand[p][best_idx[p]]);

        assert_ack_enters_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !wr_en && addr == a_cpu(p, 1) && irq_o[p])
            |=> $countones(st_q.insv) == $past($countones(st_q.insv)) + 1);

        assert_eoi_retires_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !rd_en && addr == a_cpu(p, 2) && isv_vld[p])
            |=> $countones(st_q.insv) + 1 == $past($countones(st_q.insv)));
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_chk_src
        assert_masked_never_served_R11: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.insv[s]) |-> !$past(st_q.cfg[s].mask));
    end

endmodule

// File: tb/mpic_core_tb.sv
module mpic_core_tb;

    localparam int N_SRC = 8;
    localparam int N_CPU = 2;
    localparam int AW    = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_SRC-1:0]  src = '0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              rvalid;
    logic [N_CPU-1:0]  irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    mpic_core #(.N_SRC(N_SRC), .N_CPU(N_CPU), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq)
    );

    function automatic logic [7:0] VP(int s);  return 8'(16 + 2 * s); endfunction
    function automatic logic [7:0] DST(int s); return 8'(17 + 2 * s); endfunction
    function automatic logic [7:0] TP(int p);  return 8'(64 + 4 * p); endfunction
    function automatic logic [7:0] ACK(int p); return 8'(65 + 4 * p); endfunction
    function automatic logic [7:0] EOI(int p); return 8'(66 + 4 * p); endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (rvalid === 1'b1) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2 actual=%h expected=<no read pending>", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
        @(negedge clk); rd_en = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(logic [N_SRC-1:0] m);
        @(negedge clk); src = src ^ m;
        @(negedge clk); src = src ^ m;
        repeat (2) @(negedge clk);
    endtask

    task automatic line(int s, logic v);
        @(negedge clk); src[s] = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic irq_is(logic [1:0] e, string tag);
        check(tag, 32'(irq), 32'(e));
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R8 spurious with nothing pending
        irq_is(2'b00, "R1 irq after reset");
        rd(VP(0), 32'h8000_0000, "R1 source reset word");
        rd(DST(3), 32'h0, "R1 routing reset");
        rd(TP(0), 32'd15, "R1 task priority reset");
        rd(8'h01, 32'h0000_00FF, "R1 spurious reset");
        rd(ACK(0), 32'h0000_00FF, "R8 ack with nothing pending");

        wr(TP(0), 0); wr(TP(1), 0);

        // R2 layout, R3 positive edge, R7 ack
        wr(VP(0), 32'h0085_0020); wr(DST(0), 1);
        rd(VP(0), 32'h0085_0020, "R2 configuration readback");
        pulse(8'h01);
        irq_is(2'b01, "R3 positive edge latched");
        rd(VP(0), 32'h4085_0020, "R7 active flag while pending");
        rd(ACK(0), 32'h20, "R7 ack vector");
        irq_is(2'b00, "R7 irq drops after ack");
        wr(EOI(0), 0);
        rd(VP(0), 32'h0085_0020, "R10 active cleared after eoi");

        // R3 negative edge
        wr(VP(1), 32'h0003_0021); wr(DST(1), 1);
        line(1, 1'b1);
        irq_is(2'b00, "R3 inactive transition ignored");
        line(1, 1'b0);
        irq_is(2'b01, "R3 negative edge latched");
        rd(ACK(0), 32'h21, "R3 ack negative edge vector");
        wr(EOI(0), 0);

        // R5 strict task priority gate
        wr(TP(0), 5);
        wr(VP(2), 32'h0085_0022); wr(DST(2), 1);
        pulse(8'h04);
        irq_is(2'b00, "R5 equal to task priority blocked");
        wr(TP(0), 4);
        irq_is(2'b01, "R5 above task priority delivered");
        rd(ACK(0), 32'h22, "R5 ack vector");
        wr(EOI(0), 0); wr(TP(0), 0);

        // R6 tie by lowest index, R9 in-service gate and preemption
        wr(VP(3), 32'h0087_0023); wr(DST(3), 1);
        wr(VP(4), 32'h0087_0024); wr(DST(4), 1);
        wr(VP(5), 32'h0082_0025); wr(DST(5), 1);
        pulse(8'h18);
        rd(ACK(0), 32'h23, "R6 tie goes to lowest source");
        irq_is(2'b00, "R9 equal priority blocked by in-service");
        wr(EOI(0), 0);
        rd(ACK(0), 32'h24, "R6 second of tie");
        wr(EOI(0), 0);
        pulse(8'h20);
        rd(ACK(0), 32'h25, "R6 low priority alone");
        pulse(8'h08);
        irq_is(2'b01, "R9 higher priority preempts");
        rd(ACK(0), 32'h23, "R9 preempting vector");
        wr(EOI(0), 0);
        rd(VP(3), 32'h0087_0023, "R10 eoi retired highest");
        rd(VP(5), 32'h4082_0025, "R10 lower still in service");
        wr(EOI(0), 0);
        rd(VP(5), 32'h0082_0025, "R10 second eoi");
        wr(EOI(0), 0);
        irq_is(2'b00, "R10 eoi with nothing in service");

        // R4 level high
        wr(VP(6), 32'h00C6_0026); wr(DST(6), 1);
        line(6, 1'b1);
        irq_is(2'b01, "R4 level asserted");
        line(6, 1'b0);
        irq_is(2'b00, "R4 level withdrawn");
        line(6, 1'b1);
        rd(ACK(0), 32'h26, "R4 level ack");
        irq_is(2'b00, "R4 level in service not redelivered");
        wr(EOI(0), 0);
        irq_is(2'b01, "R4 level still present after eoi");
        line(6, 1'b0);
        irq_is(2'b00, "R4 level released");

        // R4 level low
        line(7, 1'b1);
        wr(VP(7), 32'h0044_0027); wr(DST(7), 1);
        irq_is(2'b00, "R4 active-low level idle");
        line(7, 1'b0);
        irq_is(2'b01, "R4 active-low level asserted");
        rd(ACK(0), 32'h27, "R4 active-low ack");
        line(7, 1'b1);
        wr(EOI(0), 0);
        irq_is(2'b00, "R4 active-low released");

        // R11 mask records but does not deliver
        wr(VP(2), 32'h8085_0022);
        pulse(8'h04);
        irq_is(2'b00, "R11 masked not delivered");
        rd(VP(2), 32'hC085_0022, "R11 masked edge recorded");
        wr(VP(2), 32'h0085_0022);
        irq_is(2'b01, "R11 unmask delivers");
        rd(ACK(0), 32'h22, "R11 ack after unmask");
        wr(EOI(0), 0);

        // R12 routing
        wr(DST(0), 3);
        pulse(8'h01);
        irq_is(2'b01, "R12 non-multicast to lowest processor");
        rd(ACK(0), 32'h20, "R12 ack processor 0");
        wr(EOI(0), 0);
        wr(VP(0), 32'h2085_0020);
        pulse(8'h01);
        irq_is(2'b11, "R12 multicast to both");
        rd(ACK(1), 32'h20, "R12 ack processor 1");
        irq_is(2'b00, "R12 taken source leaves other processor");
        wr(EOI(1), 0);
        rd(VP(0), 32'h2085_0020, "R12 retired by processor 1");

        // R8 programmed spurious
        wr(8'h01, 32'h5A);
        rd(ACK(1), 32'h5A, "R8 programmed spurious");

        // R13 global reset
        pulse(8'h04);
        irq_is(2'b01, "R13 pending before global reset");
        wr(8'h00, 32'hA000_0000);
        irq_is(2'b00, "R13 irq cleared by global reset");
        rd(TP(0), 32'd15, "R13 task priority reset");
        rd(VP(2), 32'h8000_0000, "R13 source reset");
        rd(8'h01, 32'hFF, "R13 spurious reset");
        rd(DST(2), 32'h0, "R13 routing reset");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R2 actual=%0d expected=0 reads outstanding", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule